// File: doc/BRIEF.md
# Flash Array Program/Erase Controller

This block applies page program and erase operations to an on-chip byte array that behaves like flash. A command carries an operation code and a start address. A program command then takes a stream of bytes. Each byte is ANDed into the array, so a programmed bit can only go from 1 to 0. The byte address wraps inside the current 256-byte page. An erase command sets a whole sector, a whole block or the whole array to 0xFF. The low address bits are dropped, so the region starts on its own boundary. No page-sized erase exists.

The array geometry is set by parameters. A page is 2^PAGE_BITS bytes (256), a sector is 2^SECTOR_BITS bytes, a block is 2^BLOCK_BITS bytes and the array is 2^ADDR_W bytes. At full scale these are 4 KB sectors and 64 KB blocks. The defaults shrink sectors to 512 bytes, blocks to 1 KB and the array to 2 KB so the memory stays small. Each operation is modelled as a programmable number of busy cycles. An erase cannot finish before its region has been swept one byte per cycle. Reads go through a plain address-to-data port with one cycle of latency.

Top module: `flash_pe_ctrl`

## Requirements
- R1: After reset, busy and done are 0 and cmd_ready is 1.
- R2: A program byte stores old AND new at its address; a program command accepts 1 to 256 data bytes.
- R3: During a program, each accepted byte advances only the low PAGE_BITS of the address modulo 256; the upper address bits stay at the command's page.
- R4: Sector erase (cmd_op 1) sets every byte of the 2^SECTOR_BITS region containing cmd_addr, aligned down, to 0xFF and leaves all other bytes unchanged.
- R5: Block erase (cmd_op 2) sets the aligned 2^BLOCK_BITS region containing cmd_addr to 0xFF and leaves all other bytes unchanged.
- R6: Chip erase (cmd_op 3) sets every byte to 0xFF, whatever cmd_addr is.
- R7: An erase holds busy for exactly max(T, region bytes) cycles after acceptance, where T is T_SECT, T_BLK or T_CHIP. done is high for the one cycle after busy falls.
- R8: A program (cmd_op 0) holds busy from acceptance through the cycle of the byte flagged data_last, and then for T_PROG more cycles.
- R9: cmd_ready is low while busy. A cmd_valid or data_valid seen while busy, outside a program's data phase, is ignored: it changes neither the array nor the busy length.
- R10: A command is accepted on a clock edge where cmd_valid is high and busy is low. Data bytes are taken only after a program command has been accepted.
- R11: rd_data shows the array byte at rd_addr one clock edge after rd_addr is applied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command request |
| cmd_op | input | 2 | 0 program, 1 sector erase, 2 block erase, 3 chip erase |
| cmd_addr | input | ADDR_W | Start address |
| cmd_ready | output | 1 | Block can take a command |
| data_valid | input | 1 | Program byte present |
| data_byte | input | 8 | Program byte |
| data_last | input | 1 | Marks the final program byte |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| rd_addr | input | ADDR_W | Read address |
| rd_data | output | 8 | Read data, one cycle later |

## Verification
The hardest case to reach from the ports is a command that arrives while an erase is still sweeping its region. The stimulus starts a sector erase and, part way through, raises cmd_valid with a chip-erase code and also drives stray data bytes. Earlier programming has put known non-0xFF bytes outside that sector. A full array readback then shows whether the second command or the stray bytes had any effect. The bench also runs a program that starts two bytes before the end of a page, so its stream crosses the wrap. A second program over bytes that were already programmed shows whether bits can only be cleared.

// File: rtl/flash_pe_pkg.sv
package flash_pe_pkg;
  typedef enum logic [1:0] {
    OP_PROG  = 2'd0,
    OP_SECT  = 2'd1,
    OP_BLOCK = 2'd2,
    OP_CHIP  = 2'd3
  } pe_op_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_LOAD,
    ST_ERASE,
    ST_WAIT
  } pe_state_e;
endpackage

// File: rtl/flash_pe_array.sv
module flash_pe_array #(
  parameter int ADDR_W = 11
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              wr_and,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [7:0]        wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [7:0]        rd_data
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [7:0] mem [DEPTH];
  logic [7:0] rd_q;

  // Storage macro model: no reset on the cells.
  always_ff @(posedge clk) begin
    if (wr_en) begin
      mem[wr_addr] <= wr_and ? (mem[wr_addr] & wr_data) : wr_data;
    end
    rd_q <= mem[rd_addr];
  end

  assign rd_data = rd_q;

  // R2: a program write never sets a bit that was clear
  p_no_set_bits_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_and) |=> ((mem[$past(wr_addr)] & ~$past(mem[wr_addr])) == 8'h00));

  // R4: an erase write leaves the byte at 0xFF
  p_erase_ones_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wr_and) |=> (mem[$past(wr_addr)] == 8'hFF));
endmodule

// File: rtl/flash_pe_seq.sv
module flash_pe_seq
  import flash_pe_pkg::*;
#(
  parameter int ADDR_W      = 11,
  parameter int PAGE_BITS   = 8,
  parameter int SECTOR_BITS = 9,
  parameter int BLOCK_BITS  = 10,
  parameter int T_PROG      = 20,
  parameter int T_SECT      = 600,
  parameter int T_BLK       = 1100,
  parameter int T_CHIP      = 2300
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  input  logic [1:0]        cmd_op,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic              data_valid,
  input  logic [7:0]        data_byte,
  input  logic              data_last,
  output logic              busy,
  output logic              done,
  output logic              wr_en,
  output logic              wr_and,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [7:0]        wr_data
);
  localparam int LEN_SECT = 1 << SECTOR_BITS;
  localparam int LEN_BLK  = 1 << BLOCK_BITS;
  localparam int LEN_CHIP = 1 << ADDR_W;
  localparam int DUR_SECT = (T_SECT > LEN_SECT) ? T_SECT : LEN_SECT;
  localparam int DUR_BLK  = (T_BLK  > LEN_BLK)  ? T_BLK  : LEN_BLK;
  localparam int DUR_CHIP = (T_CHIP > LEN_CHIP) ? T_CHIP : LEN_CHIP;
  localparam int DUR_A    = (DUR_SECT > DUR_BLK) ? DUR_SECT : DUR_BLK;
  localparam int DUR_B    = (DUR_CHIP > T_PROG) ? DUR_CHIP : T_PROG;
  localparam int DUR_MAX  = (DUR_A > DUR_B) ? DUR_A : DUR_B;
  localparam int CNT_W    = $clog2(DUR_MAX + 1);
  localparam int HI_W     = ADDR_W - PAGE_BITS;

  pe_state_e             st_q, st_n;
  pe_op_e                op_q, op_n;
  logic [ADDR_W-1:0]     base_q, base_n;
  logic [PAGE_BITS-1:0]  off_q, off_n;
  logic [CNT_W-1:0]      cnt_q, cnt_n;
  logic                  done_q, done_n;
  logic [CNT_W-1:0]      len_cur, last_cur;
  logic [ADDR_W-1:0]     amask;
  logic                  cnt_en;

  // Region size and final count of the operation in flight
  always_comb begin
    unique case (op_q)
      OP_SECT:  begin len_cur = CNT_W'(LEN_SECT); last_cur = CNT_W'(DUR_SECT - 1); end
      OP_BLOCK: begin len_cur = CNT_W'(LEN_BLK);  last_cur = CNT_W'(DUR_BLK - 1);  end
      OP_CHIP:  begin len_cur = CNT_W'(LEN_CHIP); last_cur = CNT_W'(DUR_CHIP - 1); end
      default:  begin len_cur = '0;               last_cur = CNT_W'(T_PROG - 1);   end
    endcase
  end

  // Alignment mask for the incoming erase command
  always_comb begin
    unique case (pe_op_e'(cmd_op))
      OP_SECT:  amask = ~ADDR_W'(LEN_SECT - 1);
      OP_BLOCK: amask = ~ADDR_W'(LEN_BLK - 1);
      OP_CHIP:  amask = '0;
      default:  amask = '1;
    endcase
  end

  // Next state
  always_comb begin
    st_n   = st_q;
    op_n   = op_q;
    base_n = base_q;
    off_n  = off_q;
    cnt_n  = cnt_q;
    done_n = 1'b0;
    cnt_en = (st_q == ST_ERASE) || (st_q == ST_WAIT);
    unique case (st_q)
      ST_IDLE: begin
        if (cmd_valid) begin
          op_n   = pe_op_e'(cmd_op);
          base_n = cmd_addr & amask;
          off_n  = cmd_addr[PAGE_BITS-1:0];
          cnt_n  = '0;
          st_n   = (pe_op_e'(cmd_op) == OP_PROG) ? ST_LOAD : ST_ERASE;
        end
      end
      ST_LOAD: begin
        if (data_valid) begin
          off_n = off_q + 1'b1;
          if (data_last) begin
            st_n  = ST_WAIT;
            cnt_n = '0;
          end
        end
      end
      default: begin
        if (cnt_en) begin
          if (cnt_q == last_cur) begin
            st_n   = ST_IDLE;
            done_n = 1'b1;
          end else begin
            cnt_n = cnt_q + 1'b1;
          end
        end
      end
    endcase
  end

  // Registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      op_q   <= OP_PROG;
      base_q <= '0;
      off_q  <= '0;
      cnt_q  <= '0;
      done_q <= 1'b0;
    end else begin
      st_q   <= st_n;
      op_q   <= op_n;
      base_q <= base_n;
      off_q  <= off_n;
      cnt_q  <= cnt_n;
      done_q <= done_n;
    end
  end

  // Array write port
  always_comb begin
    wr_en   = 1'b0;
    wr_and  = 1'b0;
    wr_addr = base_q + ADDR_W'(cnt_q);
    wr_data = 8'hFF;
    if (st_q == ST_LOAD) begin
      wr_en   = data_valid;
      wr_and  = 1'b1;
      wr_addr = {base_q[ADDR_W-1 -: HI_W], off_q};
      wr_data = data_byte;
    end else if (st_q == ST_ERASE) begin
      wr_en = (cnt_q < len_cur);
    end
  end

  assign busy = (st_q != ST_IDLE);
  assign done = done_q;

  // R10: an operation only starts from a command request
  p_start_from_cmd_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(cmd_valid));

  // R7: the end of busy is marked by done
  p_end_gives_done_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done);

  // R7: done lasts one cycle
  p_done_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R3: consecutive program writes stay in one page
  p_page_fixed_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_and && $past(wr_en && wr_and) && $stable(busy))
      |-> (wr_addr[ADDR_W-1:PAGE_BITS] == $past(wr_addr[ADDR_W-1:PAGE_BITS])));
endmodule

// File: rtl/flash_pe_ctrl.sv
module flash_pe_ctrl #(
  parameter int ADDR_W      = 11,
  parameter int PAGE_BITS   = 8,
  parameter int SECTOR_BITS = 9,
  parameter int BLOCK_BITS  = 10,
  parameter int T_PROG      = 20,
  parameter int T_SECT      = 600,
  parameter int T_BLK       = 1100,
  parameter int T_CHIP      = 2300
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  input  logic [1:0]        cmd_op,
  input  logic [ADDR_W-1:0] cmd_addr,
  output logic              cmd_ready,
  input  logic              data_valid,
  input  logic [7:0]        data_byte,
  input  logic              data_last,
  output logic              busy,
  output logic              done,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [7:0]        rd_data
);
  logic [1:0]        rst_sync;
  logic              rst_s;
  logic              wr_en, wr_and;
  logic [ADDR_W-1:0] wr_addr;
  logic [7:0]        wr_data;

  // Assert asynchronously, release on the clock
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_s = rst_sync[1];

  flash_pe_seq #(
    .ADDR_W(ADDR_W), .PAGE_BITS(PAGE_BITS), .SECTOR_BITS(SECTOR_BITS),
    .BLOCK_BITS(BLOCK_BITS), .T_PROG(T_PROG), .T_SECT(T_SECT),
    .T_BLK(T_BLK), .T_CHIP(T_CHIP)
  ) u_seq (
    .clk(clk), .rst_n(rst_s),
    .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_addr(cmd_addr),
    .data_valid(data_valid), .data_byte(data_byte), .data_last(data_last),
    .busy(busy), .done(done),
    .wr_en(wr_en), .wr_and(wr_and), .wr_addr(wr_addr), .wr_data(wr_data)
  );

  flash_pe_array #(.ADDR_W(ADDR_W)) u_array (
    .clk(clk), .rst_n(rst_s),
    .wr_en(wr_en), .wr_and(wr_and), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data)
  );

  assign cmd_ready = !busy;
endmodule

// File: tb/flash_pe_ctrl_test.sv
module flash_pe_ctrl_test;
  localparam int AW = 11;
  localparam int N  = 1 << AW;
  localparam int TP = 20, TS = 600, TB = 1100, TC = 2300;
  localparam int LS = 512, LB = 1024;

  logic clk = 1'b0;
  logic rst_n;
  logic cmd_valid, data_valid, data_last;
  logic [1:0] cmd_op;
  logic [AW-1:0] cmd_addr, rd_addr;
  logic [7:0] data_byte, rd_data;
  logic cmd_ready, busy, done;

  logic [7:0] model [N];
  int nchk = 0, nerr = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  flash_pe_ctrl uut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_addr(cmd_addr), .cmd_ready(cmd_ready), .data_valid(data_valid),
    .data_byte(data_byte), .data_last(data_last), .busy(busy), .done(done),
    .rd_addr(rd_addr), .rd_data(rd_data)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic check_mem(input string req);
    int bad = -1;
    logic [7:0] got = 8'h00;
    for (int a = 0; a < N; a++) begin
      rd_addr = AW'(a);
      @(negedge clk);
      if (rd_data !== model[a] && bad < 0) begin
        bad = a;
        got = rd_data;
      end
    end
    if (bad >= 0) check(1'b0, req, $sformatf("array byte %0h", bad), got, model[bad]);
    else          check(1'b1, req, "array", 0, 0);
  endtask

  function automatic logic [7:0] pat(input logic [7:0] seed, input int i);
    return seed ^ 8'(i * 13);
  endfunction

  task automatic issue(input logic [1:0] op, input int addr);
    cmd_valid = 1'b1; cmd_op = op; cmd_addr = AW'(addr);
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic run_erase(input logic [1:0] op, input int addr, input int len,
                           input int dur, input string req);
    int base = (op == 2'd3) ? 0 : (addr & ~(len - 1));
    int n = 0;
    issue(op, addr);
    while (busy === 1'b1 && n < 5000) begin n++; @(negedge clk); end
    check(n == dur, "R7", "erase busy cycles", n, dur);
    check(done === 1'b1, "R7", "done after busy", done, 1);
    @(negedge clk);
    check(done === 1'b0, "R7", "done single cycle", done, 0);
    for (int a = base; a < base + len; a++) model[a] = 8'hFF;
    check_mem(req);
  endtask

  task automatic run_prog(input int addr, input int nb, input logic [7:0] seed,
                          input string req);
    int n = 0;
    int page = addr & ~255;
    issue(2'd0, addr);
    for (int i = 0; i < nb; i++) begin
      data_valid = 1'b1; data_byte = pat(seed, i); data_last = (i == nb - 1);
      if (busy === 1'b1) n++;
      @(negedge clk);
      model[page + ((addr + i) & 255)] &= pat(seed, i);
    end
    data_valid = 1'b0; data_last = 1'b0;
    while (busy === 1'b1 && n < 5000) begin n++; @(negedge clk); end
    check(n == nb + TP, "R8", "program busy cycles", n, nb + TP);
    check_mem(req);
  endtask

  task automatic t_reset;
    rst_n = 1'b0; cmd_valid = 0; cmd_op = 0; cmd_addr = 0;
    data_valid = 0; data_byte = 0; data_last = 0; rd_addr = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check(busy === 1'b0, "R1", "busy after reset", busy, 0);
    check(done === 1'b0, "R1", "done after reset", done, 0);
    check(cmd_ready === 1'b1, "R1", "cmd_ready after reset", cmd_ready, 1);
  endtask

  task automatic t_and_program;
    run_prog(16'h010, 32, 8'h5A, "R2 first");
    run_prog(16'h010, 32, 8'h0F, "R2 and");
    run_prog(16'h300, 1, 8'h12, "R2 single");
  endtask

  task automatic t_wrap;
    run_prog(16'h1FE, 5, 8'hC3, "R3 wrap");
    run_prog(16'h780, 256, 8'hA6, "R3 full page");
    run_prog(16'h540, 8, 8'h33, "R3 block data");
  endtask

  task automatic t_read_latency;
    logic [7:0] first;
    rd_addr = AW'(16'h1FF);
    @(negedge clk);
    first = rd_data;
    check(first === model[16'h1FF], "R11", "read after one edge", first, model[16'h1FF]);
    rd_addr = AW'(16'h010);
    #1;
    check(rd_data === first, "R11", "read held before edge", rd_data, first);
    @(negedge clk);
    check(rd_data === model[16'h010], "R11", "read new address", rd_data, model[16'h010]);
  endtask

  task automatic t_busy_reject;
    int n = 0;
    issue(2'd1, 16'h000);
    while (busy === 1'b1 && n < 5000) begin
      n++;
      if (n == 5) check(cmd_ready === 1'b0, "R9", "cmd_ready while busy", cmd_ready, 0);
      cmd_valid  = (n >= 5 && n < 9);
      cmd_op     = 2'd3;
      data_valid = (n >= 5 && n < 12);
      data_byte  = 8'h00;
      @(negedge clk);
    end
    cmd_valid = 1'b0; data_valid = 1'b0;
    check(n == TS, "R9", "busy length with stray command", n, TS);
    @(negedge clk);
    check(busy === 1'b0, "R9", "stray command not started", busy, 0);
    for (int a = 0; a < LS; a++) model[a] = 8'hFF;
    check_mem("R9 stray ignored");
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      nerr++; nchk++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("CHECKS %0d ERRORS %0d", nchk, nerr);
      $finish;
    end
  end

  initial begin
    for (int a = 0; a < N; a++) model[a] = 8'hFF;
    t_reset();
    run_erase(2'd3, 16'h5A5, N, TC, "R6 chip");
    t_and_program();
    t_wrap();
    t_read_latency();
    run_erase(2'd1, 16'h2A5, LS, TS, "R4 sector");
    run_prog(16'h710, 4, 8'h44, "R5 setup");
    run_erase(2'd2, 16'h7F3, LB, TB, "R5 block");
    run_prog(16'h1F0, 4, 8'h21, "R9 setup");
    run_prog(16'h620, 4, 8'h77, "R9 setup high");
    t_busy_reject();
    run_erase(2'd3, 16'h000, N, TC, "R6 chip again");
    finished = 1;
    $display("CHECKS %0d ERRORS %0d", nchk, nerr);
    $finish;
  end
endmodule